// File: doc/BRIEF.md
# Single-Level Shadow Context Register

This block gives an interrupt handler a quick way to save and restore part of the processor state. It holds one shadow copy of five arithmetic status flags (digit carry, negative, overflow, zero, carry) and of the first four 16-bit working registers. A push strobe copies every live value into the shadow at one clock edge. A pop strobe drives the saved copy back toward the live register file, together with a one-cycle restore-valid strobe.

Only one save level exists. A second push before a pop replaces the first save, and an overwrite-warning output pulses to flag that loss. Nested handlers that need more than one level must save state some other way. If push and pop arrive in the same cycle, the pop wins and the push is dropped.

Top module: `shadow_ctx_reg`

## Requirements
- R1: After reset, `rest_vld_o` and `ovwr_warn_o` are 0, and `rest_flags_o` and `rest_regs_o` are all zero. The shadow is empty (all zero) and the save-valid state is clear.
- R2: A push (`push_i`=1, `pop_i`=0) captures all of `live_flags_i` and `live_regs_i` at that one clock edge. A later pop returns exactly those values. Working register k sits at bits [16k+15:16k] of the register buses. The flag bits are: bit 4 digit carry, bit 3 negative, bit 2 overflow, bit 1 zero, bit 0 carry.
- R3: A pop sampled at a clock edge sets `rest_vld_o` to 1 after that edge and loads the shadow contents onto `rest_flags_o` and `rest_regs_o`. `rest_vld_o` is 0 after any edge at which no pop was sampled.
- R4: The shadow is one level deep. A second push before a pop overwrites the first save, and the next pop returns the second save.
- R5: `ovwr_warn_o` is 1 for the single cycle after a push that arrives while a save is held (pushed and not yet popped). Otherwise it is 0.
- R6: A pop with no save held still asserts `rest_vld_o` and returns the stale shadow contents: either the last save or the reset zeros.
- R7: When push and pop are both asserted in the same cycle, the pop takes effect and the push is ignored. The shadow is unchanged, the save-valid state clears, and `ovwr_warn_o` stays 0.
- R8: Between pops, `rest_flags_o` and `rest_regs_o` hold their last restored values whatever the live inputs do.
- R9: The shadow is written only by a push. Changes on the live inputs without a push do not change what the next pop returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Shadow-push command strobe |
| pop_i | input | 1 | Shadow-pop command strobe |
| live_flags_i | input | 5 | Live status flags {dc, n, ov, z, c} |
| live_regs_i | input | 64 | Live working registers 0..3, register k at [16k+15:16k] |
| rest_flags_o | output | 5 | Restored status flags |
| rest_regs_o | output | 64 | Restored working registers |
| rest_vld_o | output | 1 | Restore strobe, high for the cycle after a pop |
| ovwr_warn_o | output | 1 | Pulses when a push overwrites a held save |

## Verification
The bound checker watches properties that hold on every cycle. The restore strobe follows each pop by exactly one cycle. The restored data stays stable when no pop was taken. A push onto a held save always raises the warning, and a simultaneous push and pop never does. The checker also compares restored data against its own record of the last push. Only the bench's scenarios can show the end-to-end stories: a save surviving arbitrary live-input activity, a second push replacing the first, a stale pop returning reset zeros or an old save, and a dropped push leaving the shadow unchanged while the save-valid state clears.

// File: rtl/shadow_ctx_pkg.sv
package shadow_ctx_pkg;

   typedef struct packed {
      logic dc;
      logic n;
      logic ov;
      logic z;
      logic c;
   } sr_flags_t;

   localparam int FLAG_W = $bits(sr_flags_t);

   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_PUSH = 2'd1,
      CMD_POP  = 2'd2
   } shadow_cmd_e;

endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
   import shadow_ctx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push_i,
   input  logic        pop_i,
   output shadow_cmd_e cmd_o,
   output logic        warn_o
);

   logic valid_q;

   // pop has priority over push
   always_comb begin
      if (pop_i)       cmd_o = CMD_POP;
      else if (push_i) cmd_o = CMD_PUSH;
      else             cmd_o = CMD_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         warn_o  <= 1'b0;
      end else begin
         warn_o <= (cmd_o == CMD_PUSH) && valid_q;
         case (cmd_o)
            CMD_PUSH: valid_q <= 1'b1;
            CMD_POP:  valid_q <= 1'b0;
            default:  valid_q <= valid_q;
         endcase
      end
   end

endmodule

// File: rtl/shadow_slot.sv
module shadow_slot #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= '0;
      else if (cap_i) q_o <= d_i;
   end

endmodule

// File: rtl/shadow_restore.sv
module shadow_restore #(
   parameter int WIDTH = 69,
   parameter bit HOLD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             vld_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= load_i;
   end

   generate
      if (HOLD) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)      q_o <= '0;
            else if (load_i) q_o <= d_i;
         end
      end else begin : g_zero_idle
         always_ff @(posedge clk) begin
            if (!rst_n)      q_o <= '0;
            else if (load_i) q_o <= d_i;
            else             q_o <= '0;
         end
      end
   endgenerate

endmodule

// File: rtl/shadow_ctx_reg.sv
module shadow_ctx_reg
   import shadow_ctx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int NUM_REGS     = 4,
   parameter bit RESTORE_HOLD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  logic                       pop_i,
   input  logic [FLAG_W-1:0]          live_flags_i,
   input  logic [DATA_W*NUM_REGS-1:0] live_regs_i,
   output logic [FLAG_W-1:0]          rest_flags_o,
   output logic [DATA_W*NUM_REGS-1:0] rest_regs_o,
   output logic                       rest_vld_o,
   output logic                       ovwr_warn_o
);

   localparam int REG_BITS = DATA_W * NUM_REGS;
   localparam int TOTAL_W  = REG_BITS + FLAG_W;

   generate
      if (DATA_W < 1)   begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (NUM_REGS < 1) begin : g_bad_count $error("NUM_REGS must be at least 1"); end
   endgenerate

   shadow_cmd_e         cmd;
   logic                capture;
   logic [REG_BITS-1:0] shadow_regs;
   logic [FLAG_W-1:0]   shadow_flags;

   shadow_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push_i),
      .pop_i  (pop_i),
      .cmd_o  (cmd),
      .warn_o (ovwr_warn_o)
   );

   assign capture = (cmd == CMD_PUSH);

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg_slot
         shadow_slot #(.WIDTH(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (capture),
            .d_i   (live_regs_i[k*DATA_W +: DATA_W]),
            .q_o   (shadow_regs[k*DATA_W +: DATA_W])
         );
      end
   endgenerate

   shadow_slot #(.WIDTH(FLAG_W)) u_flag_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (capture),
      .d_i   (live_flags_i),
      .q_o   (shadow_flags)
   );

   shadow_restore #(.WIDTH(TOTAL_W), .HOLD(RESTORE_HOLD)) u_restore (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cmd == CMD_POP),
      .d_i    ({shadow_flags, shadow_regs}),
      .q_o    ({rest_flags_o, rest_regs_o}),
      .vld_o  (rest_vld_o)
   );

endmodule

// File: rtl/shadow_ctx_chk.sv
module shadow_ctx_chk
   import shadow_ctx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int NUM_REGS     = 4,
   parameter bit RESTORE_HOLD = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       push_i,
   input logic                       pop_i,
   input logic [FLAG_W-1:0]          live_flags_i,
   input logic [DATA_W*NUM_REGS-1:0] live_regs_i,
   input logic [FLAG_W-1:0]          rest_flags_o,
   input logic [DATA_W*NUM_REGS-1:0] rest_regs_o,
   input logic                       rest_vld_o,
   input logic                       ovwr_warn_o
);

   logic                       held_m;
   logic [DATA_W*NUM_REGS-1:0] saved_regs_m;
   logic [FLAG_W-1:0]          saved_flags_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_m        <= 1'b0;
         saved_regs_m  <= '0;
         saved_flags_m <= '0;
      end else if (pop_i) begin
         held_m <= 1'b0;
      end else if (push_i) begin
         held_m        <= 1'b1;
         saved_regs_m  <= live_regs_i;
         saved_flags_m <= live_flags_i;
      end
   end

   assert_strobe_on_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> rest_vld_o);

   assert_no_strobe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_i |=> !rest_vld_o);

   assert_restore_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> (rest_regs_o == $past(saved_regs_m)) && (rest_flags_o == $past(saved_flags_m)));

   assert_warn_on_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && held_m) |=> ovwr_warn_o);

   assert_no_warn_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && !pop_i && held_m) |=> !ovwr_warn_o);

   assert_no_warn_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i) |=> !ovwr_warn_o);

   generate
      if (RESTORE_HOLD) begin : g_hold_chk
         assert_hold_between_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !pop_i |=> ($stable(rest_regs_o) && $stable(rest_flags_o)));
      end
   endgenerate

endmodule

bind shadow_ctx_reg shadow_ctx_chk #(
   .DATA_W       (DATA_W),
   .NUM_REGS     (NUM_REGS),
   .RESTORE_HOLD (RESTORE_HOLD)
) u_chk (.*);

// File: tb/test_shadow_ctx_reg.sv
module test_shadow_ctx_reg;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int NR = 4;
   localparam int RB = DW * NR;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0;
   logic          pop_i = 1'b0;
   logic [4:0]    live_flags_i = '0;
   logic [RB-1:0] live_regs_i = '0;
   logic [4:0]    rest_flags_o;
   logic [RB-1:0] rest_regs_o;
   logic          rest_vld_o;
   logic          ovwr_warn_o;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shadow_ctx_reg #(.DATA_W(DW), .NUM_REGS(NR)) i_shadow_ctx_reg (.*);

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one cycle of strobes, sample just after the edge, then drop strobes
   task automatic step(input logic psh, input logic pp, input logic [4:0] f, input logic [RB-1:0] r);
      @(negedge clk);
      push_i = psh; pop_i = pp; live_flags_i = f; live_regs_i = r;
      @(posedge clk); #1;
      push_i = 1'b0; pop_i = 1'b0;
   endtask

   task automatic check_restore(input string req, input logic [4:0] f, input logic [RB-1:0] r);
      check(req, {127'd0, rest_vld_o}, 128'd1);
      check(req, {123'd0, rest_flags_o}, {123'd0, f});
      check(req, {64'd0, rest_regs_o}, {64'd0, r});
   endtask

   localparam logic [4:0]    FA = 5'b10101;
   localparam logic [RB-1:0] RA = 64'h1111_2222_3333_4444;
   localparam logic [4:0]    FB = 5'b01011;
   localparam logic [RB-1:0] RB_V = 64'hDEAD_BEEF_0F0F_8001;
   localparam logic [4:0]    FC = 5'b11111;
   localparam logic [RB-1:0] RC = 64'hFFFF_0000_A5A5_5A5A;
   localparam logic [4:0]    FD = 5'b00001;
   localparam logic [RB-1:0] RD = 64'h0123_4567_89AB_CDEF;

   task automatic t_reset();
      check("R1 vld", {127'd0, rest_vld_o}, 128'd0);
      check("R1 warn", {127'd0, ovwr_warn_o}, 128'd0);
      check("R1 flags", {123'd0, rest_flags_o}, 128'd0);
      check("R1 regs", {64'd0, rest_regs_o}, 128'd0);
      step(1'b0, 1'b1, FD, RD);          // pop with empty shadow
      check_restore("R6 empty pop", 5'd0, '0);
      step(1'b0, 1'b0, FD, RD);
      check("R3 strobe drops", {127'd0, rest_vld_o}, 128'd0);
   endtask

   task automatic t_push_pop();
      step(1'b1, 1'b0, FA, RA);
      check("R5 first push no warn", {127'd0, ovwr_warn_o}, 128'd0);
      check("R3 no strobe on push", {127'd0, rest_vld_o}, 128'd0);
      step(1'b0, 1'b0, FB, RB_V);        // live inputs move, no push
      step(1'b0, 1'b0, FC, RC);
      step(1'b0, 1'b1, FD, RD);
      check_restore("R2 R9 pop returns save", FA, RA);
      step(1'b0, 1'b0, FB, RB_V);
      check("R3 one-cycle strobe", {127'd0, rest_vld_o}, 128'd0);
      check("R8 flags held", {123'd0, rest_flags_o}, {123'd0, FA});
      check("R8 regs held", {64'd0, rest_regs_o}, {64'd0, RA});
   endtask

   task automatic t_overwrite();
      step(1'b1, 1'b0, FA, RA);
      check("R5 push after pop no warn", {127'd0, ovwr_warn_o}, 128'd0);
      step(1'b1, 1'b0, FB, RB_V);
      check("R5 overwrite warn", {127'd0, ovwr_warn_o}, 128'd1);
      step(1'b0, 1'b0, FC, RC);
      check("R5 warn one cycle", {127'd0, ovwr_warn_o}, 128'd0);
      step(1'b0, 1'b1, FC, RC);
      check_restore("R4 second save wins", FB, RB_V);
   endtask

   task automatic t_stale();
      step(1'b0, 1'b1, FA, RA);
      check_restore("R6 stale pop", FB, RB_V);
      step(1'b1, 1'b0, FC, RC);
      check("R5 push on cleared save", {127'd0, ovwr_warn_o}, 128'd0);
   endtask

   task automatic t_collide();
      step(1'b1, 1'b1, FD, RD);          // save C is held; push of D dropped
      check_restore("R7 pop wins", FC, RC);
      check("R7 no warn", {127'd0, ovwr_warn_o}, 128'd0);
      step(1'b0, 1'b1, FA, RA);
      check_restore("R7 shadow unchanged", FC, RC);
      step(1'b1, 1'b0, FA, RA);
      step(1'b1, 1'b1, FB, RB_V);        // clears valid
      step(1'b1, 1'b0, FD, RD);
      check("R7 valid cleared by collide", {127'd0, ovwr_warn_o}, 128'd0);
      step(1'b0, 1'b1, FA, RA);
      check_restore("R7 later push works", FD, RD);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      t_reset();
      t_push_pop();
      t_overwrite();
      t_stale();
      t_collide();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

endmodule